// File: doc/BRIEF.md
# Full-Frame CCD Line Transfer Sequencer

This block produces the digital control levels that move charge out of a full-frame CCD one line at a time. For every line it pulses the two vertical phases to shift a row into the horizontal register, waits out a horizontal setup interval, and then clocks the horizontal register for a fixed number of pixel periods. During those periods it drives a reset-gate pulse and a one-cycle sample strobe for each pixel. Analog level shifting and the clock drivers sit outside the block. Every minimum delay is a parameter counted in system clock cycles.

Two readout modes are supported. In split mode each line goes into the first horizontal register and is read out directly. In parallel-split mode one line is first loaded into the first register. It is then handed through the transfer gate into the second register, in the order vertical fall, first-register release, transfer gate. A second line is loaded into the first register before both are shifted out together. A start command begins a frame, the mode is captured at that moment, and a busy flag covers the whole frame. The pixel clock enable sets the pixel rate: each enabled cycle advances the horizontal phases by one half pixel.

Top module: `ccd_line_sequencer`

## Requirements
- R1: During reset, and after reset until a start is accepted, every phase output, the sample strobe and busy are low. Both vertical phases are therefore held low during integration.
- R2: Each high pulse on the first vertical phase and on the second vertical phase lasts exactly V_PULSE cycles, and the two phases are never high together.
- R3: The first-register phase is high in the first cycle after the second vertical phase falls. When that fall is followed by readout and the enable is held high, the first-register phase falls exactly H_SETUP+1 cycles after the vertical fall.
- R4: Each line (or line pair) is shifted for PIXELS pixel periods. In each period the last-gate phase and the reset gate are high for the first half and the second horizontal phase for the second half, so exactly one reset pulse occurs per pixel and the first and second horizontal phases are never high together.
- R5: The sample strobe is a one-cycle pulse in the first cycle that the last-gate phase is low after a falling edge of that phase, once per pixel.
- R6: In split mode (modeSel = 0) the transfer gate and the second-register phase stay low, LINES lines are read, and with the enable held high busy lasts LINES*(2*V_PULSE+H_SETUP+2*PIXELS) cycles.
- R7: In parallel-split mode, after the first line of a pair is loaded, the first-register phase falls V2_TO_H1A cycles after the second vertical phase falls. The transfer gate then rises H1A_TO_XG cycles later, stays high XG_WIDTH cycles, and the first vertical phase rises XG_TO_V cycles after the transfer gate falls.
- R8: In parallel-split mode (modeSel = 1) LINES/2 line pairs are read. The second-register phase has PIXELS+1 rising edges per pair: one with the transfer gate, and the rest merged with setup and pixel clocking. With the enable held high, busy lasts (LINES/2)*(4*V_PULSE+V2_TO_H1A+H1A_TO_XG+XG_WIDTH+XG_TO_V+H_SETUP+2*PIXELS) cycles.
- R9: The mode is captured when a start is accepted. A start or a mode change while busy has no effect on the running frame.
- R10: Busy rises in the cycle after a start is accepted and falls after the last pixel of the last line. If start is held across the end of a frame, busy stays low for exactly one cycle before the next frame begins.
- R11: The horizontal phases advance only on cycles with the pixel clock enable high, so within a line consecutive sample strobes are 2*D cycles apart when the enable is high one cycle in D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| startReq | input | 1 | Start a frame readout (taken only when idle) |
| modeSel | input | 1 | 0 = split readout, 1 = parallel-split readout |
| pixEn | input | 1 | Pixel clock enable; one half pixel per enabled cycle |
| v1 | output | 1 | First vertical phase |
| v2 | output | 1 | Second vertical phase |
| h1a | output | 1 | Horizontal phase 1, first register |
| h1b | output | 1 | Horizontal phase 1, second register |
| h1Last | output | 1 | Last horizontal gate before the output node |
| h2 | output | 1 | Horizontal phase 2 |
| xg | output | 1 | Transfer gate between the two horizontal registers |
| rg | output | 1 | Reset gate of the output node |
| sampleStb | output | 1 | One-cycle strobe after each new charge packet |
| busy | output | 1 | Frame readout in progress |

## Verification
Two things can happen on the same clock edge: the completion of the final pixel of a frame and a start request. The bench provokes this by holding start high through a whole frame. At the edge where the last pixel finishes, start must still be ignored, because the block is busy. It must then be taken on the next edge, so the bench judges the idle gap in busy to be exactly one cycle and checks that the second frame runs to completion. A second overlap comes from a start with the opposite mode arriving mid-frame. It is judged by the transfer gate count, the strobe count and the busy length of the frame already running.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_VONE,
    S_VTWO,
    S_HOLDA,
    S_GAPA,
    S_XFER,
    S_SETTLE,
    S_SETUP,
    S_SHIFT
  } seqState_t;

  // Strobes and levels from the control FSM to the datapath.
  typedef struct packed {
    logic v1;
    logic v2;
    logic h1a;
    logic h1b;
    logic xg;
    logic shiftEn;
    logic dps;
    logic lineStep;
    logic frameStart;
  } seqCtl_t;

endpackage

// File: rtl/ccdseq_ctrl.sv
module ccdseq_ctrl
  import ccdseq_pkg::*;
#(
  parameter int V_PULSE    = 2000,
  parameter int V2_TO_H1A  = 500,
  parameter int H1A_TO_XG  = 3000,
  parameter int XG_WIDTH   = 500,
  parameter int XG_TO_V    = 500,
  parameter int H_SETUP    = 500
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    startReq,
  input  logic    modeSel,
  input  logic    pixDone,
  input  logic    lastLine,
  output seqCtl_t ctl,
  output logic    busy
);

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int TMAX = maxOf(maxOf(maxOf(V_PULSE, V2_TO_H1A), maxOf(H1A_TO_XG, XG_WIDTH)),
                              maxOf(XG_TO_V, H_SETUP));
  localparam int TW   = $clog2(TMAX + 1);

  localparam logic [TW-1:0] LD_V     = TW'(V_PULSE - 1);
  localparam logic [TW-1:0] LD_HOLD  = TW'(V2_TO_H1A - 1);
  localparam logic [TW-1:0] LD_GAP   = TW'(H1A_TO_XG - 1);
  localparam logic [TW-1:0] LD_XG    = TW'(XG_WIDTH - 1);
  localparam logic [TW-1:0] LD_SETL  = TW'(XG_TO_V - 1);
  localparam logic [TW-1:0] LD_SETUP = TW'(H_SETUP - 1);

  seqState_t st, stN;
  logic [TW-1:0] tmr, tmrN;
  logic dpsQ, dpsN;
  logic secondQ, secondN;
  logic tmrZero;
  logic frameStart, lineStep;

  assign tmrZero = (tmr == '0);

  always_comb begin
    stN        = st;
    tmrN       = tmrZero ? '0 : tmr - TW'(1);
    dpsN       = dpsQ;
    secondN    = secondQ;
    frameStart = 1'b0;
    lineStep   = 1'b0;
    unique case (st)
      S_IDLE: if (startReq) begin
        stN        = S_VONE;
        tmrN       = LD_V;
        dpsN       = modeSel;
        secondN    = 1'b0;
        frameStart = 1'b1;
      end
      S_VONE: if (tmrZero) begin
        stN  = S_VTWO;
        tmrN = LD_V;
      end
      S_VTWO: if (tmrZero) begin
        if (dpsQ && !secondQ) begin
          stN  = S_HOLDA;
          tmrN = LD_HOLD;
        end else begin
          stN  = S_SETUP;
          tmrN = LD_SETUP;
        end
      end
      S_HOLDA: if (tmrZero) begin
        stN  = S_GAPA;
        tmrN = LD_GAP;
      end
      S_GAPA: if (tmrZero) begin
        stN  = S_XFER;
        tmrN = LD_XG;
      end
      S_XFER: if (tmrZero) begin
        stN  = S_SETTLE;
        tmrN = LD_SETL;
      end
      S_SETTLE: if (tmrZero) begin
        stN     = S_VONE;
        tmrN    = LD_V;
        secondN = 1'b1;
      end
      S_SETUP: if (tmrZero) begin
        stN = S_SHIFT;
      end
      S_SHIFT: if (pixDone) begin
        lineStep = 1'b1;
        secondN  = 1'b0;
        if (lastLine) begin
          stN = S_IDLE;
        end else begin
          stN  = S_VONE;
          tmrN = LD_V;
        end
      end
      default: stN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      tmr     <= '0;
      dpsQ    <= 1'b0;
      secondQ <= 1'b0;
    end else begin
      st      <= stN;
      tmr     <= tmrN;
      dpsQ    <= dpsN;
      secondQ <= secondN;
    end
  end

  always_comb begin
    ctl            = '0;
    ctl.v1         = (st == S_VONE);
    ctl.v2         = (st == S_VTWO);
    ctl.h1a        = (st == S_VTWO) || (st == S_HOLDA) || (st == S_SETUP);
    ctl.h1b        = (st == S_XFER) || ((st == S_SETUP) && dpsQ);
    ctl.xg         = (st == S_XFER);
    ctl.shiftEn    = (st == S_SHIFT);
    ctl.dps        = dpsQ;
    ctl.lineStep   = lineStep;
    ctl.frameStart = frameStart;
  end

  assign busy = (st != S_IDLE);

  AST_V2FALL_H1A_HIGH: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == S_VTWO && st != S_VTWO) |-> ctl.h1a); // R3

  AST_XG_SPLIT_LOW: assert property (@(posedge clk) disable iff (rst)
    (busy && !dpsQ) |-> !ctl.xg); // R6

  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(startReq)); // R10

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(dpsQ)); // R9

endmodule

// File: rtl/ccdseq_dpath.sv
module ccdseq_dpath
  import ccdseq_pkg::*;
#(
  parameter int PIXELS = 4152,
  parameter int LINES  = 6220
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    pixEn,
  input  seqCtl_t ctl,
  output logic    pixDone,
  output logic    lastLine,
  output logic    v1,
  output logic    v2,
  output logic    h1a,
  output logic    h1b,
  output logic    h1Last,
  output logic    h2,
  output logic    xg,
  output logic    rg,
  output logic    sampleStb
);

  localparam int PW = $clog2(PIXELS + 1);
  localparam int LW = $clog2(LINES + 1);
  localparam logic [PW-1:0] PIX_LAST  = PW'(PIXELS - 1);
  localparam logic [LW-1:0] LAST_SPLIT = LW'(LINES - 1);
  localparam logic [LW-1:0] LAST_PAIR  = LW'(LINES / 2 - 1);

  logic          phase;     // 0: first half (H1 high), 1: second half (H2 high)
  logic [PW-1:0] pixCnt;
  logic [LW-1:0] lineCnt;
  logic          stbQ;

  assign pixDone  = ctl.shiftEn && pixEn && phase && (pixCnt == PIX_LAST);
  assign lastLine = (lineCnt == (ctl.dps ? LAST_PAIR : LAST_SPLIT));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= 1'b0;
      pixCnt <= '0;
    end else if (!ctl.shiftEn) begin
      phase  <= 1'b0;
      pixCnt <= '0;
    end else if (pixEn) begin
      phase <= ~phase;
      if (phase) begin
        pixCnt <= (pixCnt == PIX_LAST) ? '0 : pixCnt + PW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.frameStart) begin
      lineCnt <= '0;
    end else if (ctl.lineStep) begin
      lineCnt <= lineCnt + LW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stbQ <= 1'b0;
    end else begin
      stbQ <= ctl.shiftEn && pixEn && !phase;
    end
  end

  assign v1        = ctl.v1;
  assign v2        = ctl.v2;
  assign xg        = ctl.xg;
  assign h1a       = ctl.shiftEn ? ~phase : ctl.h1a;
  assign h1b       = ctl.shiftEn ? (ctl.dps & ~phase) : ctl.h1b;
  assign h1Last    = ctl.shiftEn & ~phase;
  assign h2        = ctl.shiftEn & phase;
  assign rg        = ctl.shiftEn & ~phase;
  assign sampleStb = stbQ;

  AST_STROBE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    sampleStb |-> (!h1Last && $past(h1Last))); // R5

  AST_PIX_BOUND: assert property (@(posedge clk) disable iff (rst)
    pixCnt < PW'(PIXELS)); // R4

  AST_HOLD_NO_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (ctl.shiftEn && !pixEn) |=> $stable(h2)); // R11

endmodule

// File: rtl/ccd_line_sequencer.sv
module ccd_line_sequencer
  import ccdseq_pkg::*;
#(
  parameter int PIXELS    = 4152,
  parameter int LINES     = 6220,
  parameter int V_PULSE   = 2000,
  parameter int V2_TO_H1A = 500,
  parameter int H1A_TO_XG = 3000,
  parameter int XG_WIDTH  = 500,
  parameter int XG_TO_V   = 500,
  parameter int H_SETUP   = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic startReq,
  input  logic modeSel,
  input  logic pixEn,
  output logic v1,
  output logic v2,
  output logic h1a,
  output logic h1b,
  output logic h1Last,
  output logic h2,
  output logic xg,
  output logic rg,
  output logic sampleStb,
  output logic busy
);

  seqCtl_t ctl;
  logic    pixDone;
  logic    lastLine;

  ccdseq_ctrl #(
    .V_PULSE  (V_PULSE),
    .V2_TO_H1A(V2_TO_H1A),
    .H1A_TO_XG(H1A_TO_XG),
    .XG_WIDTH (XG_WIDTH),
    .XG_TO_V  (XG_TO_V),
    .H_SETUP  (H_SETUP)
  ) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .startReq(startReq),
    .modeSel (modeSel),
    .pixDone (pixDone),
    .lastLine(lastLine),
    .ctl     (ctl),
    .busy    (busy)
  );

  ccdseq_dpath #(
    .PIXELS(PIXELS),
    .LINES (LINES)
  ) uDpath (
    .clk      (clk),
    .rst      (rst),
    .pixEn    (pixEn),
    .ctl      (ctl),
    .pixDone  (pixDone),
    .lastLine (lastLine),
    .v1       (v1),
    .v2       (v2),
    .h1a      (h1a),
    .h1b      (h1b),
    .h1Last   (h1Last),
    .h2       (h2),
    .xg       (xg),
    .rg       (rg),
    .sampleStb(sampleStb)
  );

  AST_V_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    v1 |=> !(v1 && v2)); // R2

endmodule

// File: tb/tb_ccd_line_sequencer.sv
module tb_ccd_line_sequencer;

  localparam int PIX = 4;
  localparam int LNS = 4;
  localparam int TV  = 3;
  localparam int TD1 = 2;
  localparam int TD2 = 4;
  localparam int TXW = 2;
  localparam int TD3 = 2;
  localparam int THS = 2;
  localparam int PAIRS = LNS / 2;
  localparam int BUSY_SPLIT = LNS * (2*TV + THS + 2*PIX);
  localparam int BUSY_PAIR  = PAIRS * (4*TV + TD1 + TD2 + TXW + TD3 + THS + 2*PIX);

  localparam int NV = 5;
  localparam int VEC_MODE [NV] = '{0, 1, 0, 1, 1};
  localparam int VEC_DIV  [NV] = '{1, 1, 3, 2, 5};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startReq = 1'b0;
  logic modeSel = 1'b0;
  logic pixEn = 1'b1;
  logic v1, v2, h1a, h1b, h1Last, h2, xg, rg, sampleStb, busy;

  int nChk = 0;
  int nFail = 0;
  int cyc = 0;
  int curMode = 0;
  int curDiv = 1;
  int divCnt = 0;
  bit monOn = 1'b0;

  int busyCyc, strobes, xgPulses, rgRises, h1bRises, v2Falls;
  bit ovl;
  int runV1, runV2, runXg;
  int tV2F, tAF, tXF, tStb;
  bit pendH, pendV, stbValid;
  logic pV1, pV2, pXg, pH1a, pH1b, pH1L, pRg;

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  ccd_line_sequencer #(
    .PIXELS(PIX), .LINES(LNS), .V_PULSE(TV), .V2_TO_H1A(TD1),
    .H1A_TO_XG(TD2), .XG_WIDTH(TXW), .XG_TO_V(TD3), .H_SETUP(THS)
  ) dut (
    .clk(clk), .rst(rst), .startReq(startReq), .modeSel(modeSel), .pixEn(pixEn),
    .v1(v1), .v2(v2), .h1a(h1a), .h1b(h1b), .h1Last(h1Last), .h2(h2),
    .xg(xg), .rg(rg), .sampleStb(sampleStb), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearStats();
    busyCyc = 0; strobes = 0; xgPulses = 0; rgRises = 0; h1bRises = 0; v2Falls = 0;
    ovl = 1'b0; runV1 = 0; runV2 = 0; runXg = 0;
    tV2F = 0; tAF = 0; tXF = 0; tStb = 0;
    pendH = 1'b0; pendV = 1'b0; stbValid = 1'b0;
    pV1 = v1; pV2 = v2; pXg = xg; pH1a = h1a; pH1b = h1b; pH1L = h1Last; pRg = rg;
  endtask

  // Pixel clock enable: high one cycle in curDiv.
  initial begin
    forever begin
      @(negedge clk);
      if (divCnt >= curDiv - 1) divCnt = 0;
      else divCnt = divCnt + 1;
      pixEn = (divCnt == 0);
    end
  end

  // Event monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (monOn) begin
      if (busy) busyCyc++;
      if (v1 && v2) ovl = 1'b1;
      if (h1Last && h2) ovl = 1'b1;
      if (h1a && h2) ovl = 1'b1;
      if (v1) runV1++;
      if (v2) runV2++;
      if (xg) runXg++;
      if (pV1 && !v1) begin
        check(runV1 == TV, "R2 v1 width", runV1, TV);
        runV1 = 0;
      end
      if (!pV1 && v1) begin
        stbValid = 1'b0;
        if (pendV) begin
          check(cyc - tXF == TD3, "R7 xg fall to v1 rise", cyc - tXF, TD3);
          pendV = 1'b0;
        end
      end
      if (pV2 && !v2) begin
        check(runV2 == TV, "R2 v2 width", runV2, TV);
        runV2 = 0;
        check(h1a == 1'b1, "R3 h1a high at v2 fall", int'(h1a), 1);
        tV2F = cyc;
        pendH = 1'b1;
        v2Falls++;
      end
      if (pH1a && !h1a) begin
        tAF = cyc;
        if (pendH) begin
          pendH = 1'b0;
          if (curMode == 1 && (v2Falls % 2) == 1)
            check(cyc - tV2F == TD1, "R7 v2 fall to h1a fall", cyc - tV2F, TD1);
          else if (curDiv == 1)
            check(cyc - tV2F == THS + 1, "R3 setup to first h1 fall", cyc - tV2F, THS + 1);
        end
      end
      if (!pXg && xg) begin
        xgPulses++;
        check(cyc - tAF == TD2, "R7 h1a fall to xg rise", cyc - tAF, TD2);
      end
      if (pXg && !xg) begin
        check(runXg == TXW, "R7 xg width", runXg, TXW);
        runXg = 0;
        tXF = cyc;
        pendV = 1'b1;
      end
      if (!pH1b && h1b) h1bRises++;
      if (!pRg && rg) rgRises++;
      if (sampleStb) begin
        strobes++;
        check(!h1Last && pH1L, "R5 strobe after h1Last fall", int'(h1Last), 0);
        if (stbValid && curDiv > 1)
          check(cyc - tStb == 2*curDiv, "R11 strobe spacing", cyc - tStb, 2*curDiv);
        tStb = cyc;
        stbValid = 1'b1;
      end
      pV1 = v1; pV2 = v2; pXg = xg; pH1a = h1a; pH1b = h1b; pH1L = h1Last; pRg = rg;
    end
  end

  task automatic waitIdle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic runFrame(input int mode, input int div, input bit poke);
    @(negedge clk);
    curMode = mode;
    curDiv = div;
    clearStats();
    monOn = 1'b1;
    modeSel = mode[0];
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      modeSel = ~mode[0];
      startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
      modeSel = mode[0];
    end
    waitIdle();
    monOn = 1'b0;
  endtask

  task automatic frameChecks(input int mode, input int div, input string tag);
    int units;
    units = (mode == 1) ? PAIRS : LNS;
    check(strobes == units * PIX, {tag, " R5 strobe count"}, strobes, units * PIX);
    check(rgRises == units * PIX, {tag, " R4 reset pulses"}, rgRises, units * PIX);
    check(!ovl, {tag, " R2 R4 phase overlap"}, int'(ovl), 0);
    if (mode == 1) begin
      check(xgPulses == PAIRS, {tag, " R7 xg pulses"}, xgPulses, PAIRS);
      check(h1bRises == PAIRS * (PIX + 1), {tag, " R8 h1b rises"}, h1bRises, PAIRS * (PIX + 1));
      if (div == 1) check(busyCyc == BUSY_PAIR, {tag, " R8 busy length"}, busyCyc, BUSY_PAIR);
    end else begin
      check(xgPulses == 0, {tag, " R6 xg idle"}, xgPulses, 0);
      check(h1bRises == 0, {tag, " R6 h1b idle"}, h1bRises, 0);
      if (div == 1) check(busyCyc == BUSY_SPLIT, {tag, " R6 busy length"}, busyCyc, BUSY_SPLIT);
    end
  endtask

  task automatic checkQuiet(input string req);
    logic [9:0] outs;
    outs = {v1, v2, h1a, h1b, h1Last, h2, xg, rg, sampleStb, busy};
    check(outs == '0, req, int'(outs), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    int gap;
    repeat (3) @(negedge clk);
    checkQuiet("R1 outputs in reset");
    rst = 1'b0;
    repeat (3) @(negedge clk);
    checkQuiet("R1 outputs idle after reset");

    // Vector table walk.
    for (int i = 0; i < NV; i++) begin
      runFrame(VEC_MODE[i], VEC_DIV[i], 1'b0);
      frameChecks(VEC_MODE[i], VEC_DIV[i], "vec");
      checkQuiet("R1 idle after frame");
    end

    // R9: start with the other mode while busy is ignored.
    runFrame(0, 1, 1'b1);
    frameChecks(0, 1, "R9 poke split");
    runFrame(1, 1, 1'b1);
    frameChecks(1, 1, "R9 poke pair");

    // R10: start held through the end of a frame.
    @(negedge clk);
    curDiv = 1;
    modeSel = 1'b0;
    startReq = 1'b1;
    @(negedge clk);
    check(busy == 1'b1, "R10 busy after start", int'(busy), 1);
    while (busy) @(negedge clk);
    gap = 0;
    while (!busy && gap < 10) begin
      gap++;
      @(negedge clk);
    end
    startReq = 1'b0;
    check(gap == 1, "R10 idle gap with start held", gap, 1);
    waitIdle();
    checkQuiet("R10 second frame ends");

    // R1: reset in the middle of a frame.
    @(negedge clk);
    modeSel = 1'b1;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (17) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    checkQuiet("R1 outputs after mid-frame reset");
    rst = 1'b0;
    repeat (4) @(negedge clk);
    checkQuiet("R1 idle after mid-frame reset");

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule